// File: doc/BRIEF.md
# Simulation Exit Port with Boundary Halt

This block is a memory-mapped exit port for simulation and for bring-up silicon. It is paired with the halt sequencing of a small multicycle core. Software ends a run by storing a 32-bit exit code as a full word to one fixed platform address. The port keeps that code in a register and drives it on a top-level output. By convention, 1 means the run passed and 31 means it failed. The same store raises a halt pulse for a single clock.

The core turns that pulse into a sticky halt request. It honours the request only at an instruction boundary, when its sequencer leaves writeback for fetch. An instruction already in flight therefore always retires first. No instruction pattern can halt the core. A jump to itself, which compilers emit as a safety spin, keeps running like any other jump. The core here is a sequencer stub with five states (fetch, decode, execute, memory, writeback). It takes one instruction word per fetch and computes only its next program counter.

Top module: `sim_exit_top`

## Requirements
- R1: A write with `bus_valid`=1, `bus_we`=1, `bus_be`=4'b1111 and `bus_addr`=32'h1000_1FF8 stores `bus_wdata` into `halt_code`, visible from the clock edge that accepts the write. `halt_code` is 0 after reset.
- R2: That write drives `halt_pulse` high for exactly the one cycle that follows the accepting edge.
- R3: A write to the exit address with any byte enable other than 4'b1111 leaves `halt_code` unchanged, gives no pulse and causes no halt.
- R4: A write of any width to another address leaves `halt_code` unchanged, gives no pulse and causes no halt.
- R5: A read (`bus_valid`=1, `bus_we`=0) of the exit address returns `halt_code` combinationally on `bus_rdata`. The read changes nothing and causes no halt. Reads of other addresses return 0.
- R6: After a synchronous active-high reset, the core is in fetch with `core_req`=1, `core_addr`=RESET_PC (32'h0000_0000), `halted`=0 and `retire`=0.
- R7: Each instruction takes exactly five cycles. `core_req` is high only in the fetch cycle, and `retire` is high only in the writeback cycle. The fetch cycle directly follows each writeback unless the core halts.
- R8: Let cycle S be the cycle in which `halt_pulse` is high. The core retires its first instruction whose writeback cycle W comes after S, and `halted` rises in cycle W+1. Instructions in flight are never cut short.
- R9: Once high, `halted` stays high until reset. While it is high, `core_req` and `retire` stay low.
- R10: The word 32'h0000_006F (jump with zero offset) executes as a normal jump. The PC stays the same, `retire` keeps pulsing every five cycles and the core never halts.
- R11: After each retire, the next fetch address is PC+4. For a jump (opcode bits [6:0]=7'b1101111), it is instead PC plus the sign-extended jump offset held in bits [31], [19:12], [20] and [30:21] of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | MMIO access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables of a write |
| bus_addr | input | 32 | MMIO byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (exit code at the exit address, else 0) |
| fetch_data | input | 32 | Instruction word returned for the current fetch |
| core_req | output | 1 | Core fetch request |
| core_addr | output | 32 | Core program counter / fetch address |
| retire | output | 1 | High in the writeback cycle of each instruction |
| halted | output | 1 | Core has stopped at an instruction boundary |
| halt_pulse | output | 1 | One-cycle pulse after an accepted exit write |
| halt_code | output | 32 | Last exit code written |

## Verification
A wrong decode in the exit port shows at the ports one cycle after the write. Either `halt_code` fails to follow a full-word store, or a partial or misaddressed store changes it or raises `halt_pulse`. A halt flag that is lost, taken at the wrong boundary or not held shows within five cycles of the pulse. `halted` then rises one writeback too early or too late, or falls again, or a `retire` or `core_req` appears after it. A fault in the sequencer or the next-PC logic shows at the next fetch, through the five-cycle spacing of `retire` and the value of `core_addr`.

// File: rtl/sim_exit_pkg.sv
package sim_exit_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4,
    ST_HALT   = 3'd5
  } seq_state_t;

  localparam logic [6:0] OPC_JUMP = 7'b1101111;

  function automatic logic [XLEN-1:0] jump_offset(input logic [XLEN-1:0] iw);
    jump_offset = {{(XLEN-20){iw[31]}}, iw[19:12], iw[20], iw[30:21], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] next_pc(input logic [XLEN-1:0] pc,
                                              input logic [XLEN-1:0] iw);
    if (iw[6:0] == OPC_JUMP) next_pc = pc + jump_offset(iw);
    else                     next_pc = pc + XLEN'(4);
  endfunction
endpackage

// File: rtl/exit_port.sv
module exit_port #(
  parameter int unsigned     AW        = 32,
  parameter int unsigned     DW        = 32,
  parameter logic [AW-1:0]   EXIT_ADDR = 32'h1000_1FF8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_valid,
  input  logic            bus_we,
  input  logic [DW/8-1:0] bus_be,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            word_hit,
  output logic            pulse,
  output logic [DW-1:0]   code
);
  localparam int unsigned BEW = DW / 8;

  logic addr_match;
  assign addr_match = (bus_addr == EXIT_ADDR);
  assign word_hit   = bus_valid && bus_we && addr_match && (bus_be == {BEW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= word_hit;
      if (word_hit) code <= bus_wdata;
    end
  end

  assign bus_rdata = (bus_valid && !bus_we && addr_match) ? code : '0;
endmodule

// File: rtl/core_seq.sv
module core_seq
  import sim_exit_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_halt,
  input  logic [XLEN-1:0] fetch_data,
  output logic            core_req,
  output logic [XLEN-1:0] core_addr,
  output logic            retire,
  output logic            halted,
  output logic            halt_flag
);
  seq_state_t      state, state_nx;
  logic [XLEN-1:0] pc, ir;

  always_comb begin
    unique case (state)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: state_nx = ST_EXEC;
      ST_EXEC:   state_nx = ST_MEM;
      ST_MEM:    state_nx = ST_WB;
      ST_WB:     state_nx = halt_flag ? ST_HALT : ST_FETCH;
      default:   state_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      pc        <= RESET_PC;
      ir        <= '0;
      halt_flag <= 1'b0;
    end else begin
      state     <= state_nx;
      halt_flag <= halt_flag | ext_halt;
      if (state == ST_FETCH) ir <= fetch_data;
      if (state == ST_WB)    pc <= next_pc(pc, ir);
    end
  end

  assign core_req  = (state == ST_FETCH);
  assign core_addr = pc;
  assign retire    = (state == ST_WB);
  assign halted    = (state == ST_HALT);
endmodule

// File: rtl/sim_exit_top.sv
module sim_exit_top
  import sim_exit_pkg::*;
#(
  parameter logic [XLEN-1:0] EXIT_ADDR = 32'h1000_1FF8,
  parameter logic [XLEN-1:0] RESET_PC  = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_valid,
  input  logic            bus_we,
  input  logic [3:0]      bus_be,
  input  logic [XLEN-1:0] bus_addr,
  input  logic [XLEN-1:0] bus_wdata,
  output logic [XLEN-1:0] bus_rdata,
  input  logic [XLEN-1:0] fetch_data,
  output logic            core_req,
  output logic [XLEN-1:0] core_addr,
  output logic            retire,
  output logic            halted,
  output logic            halt_pulse,
  output logic [XLEN-1:0] halt_code
);
  logic exit_word_hit;
  logic core_halt_flag;

  exit_port #(.AW(XLEN), .DW(XLEN), .EXIT_ADDR(EXIT_ADDR)) u_port (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .word_hit(exit_word_hit), .pulse(halt_pulse), .code(halt_code)
  );

  core_seq #(.RESET_PC(RESET_PC)) u_core (
    .clk(clk), .rst(rst), .ext_halt(halt_pulse), .fetch_data(fetch_data),
    .core_req(core_req), .core_addr(core_addr), .retire(retire),
    .halted(halted), .halt_flag(core_halt_flag)
  );
endmodule

// File: rtl/sim_exit_chk.sv
module sim_exit_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        word_hit,
  input logic        halt_flag,
  input logic        halt_pulse,
  input logic [31:0] halt_code,
  input logic        core_req,
  input logic        retire,
  input logic        halted
);
  // R1
  code_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    word_hit |=> halt_code == $past(bus_wdata));
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |=> !halt_pulse);
  // R3
  pulse_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |-> $past(bus_valid && bus_we && bus_be == 4'hF));
  // R5
  read_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we) |=> $stable(halt_code));
  // R7
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    retire |=> (core_req || halted));
  // R8
  halt_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(retire) && $past(halt_flag));
  // R8
  flag_from_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |=> halt_flag);
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !core_req && !retire);
endmodule

bind sim_exit_top sim_exit_chk u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .word_hit(exit_word_hit),
  .halt_flag(core_halt_flag), .halt_pulse(halt_pulse), .halt_code(halt_code),
  .core_req(core_req), .retire(retire), .halted(halted)
);

// File: tb/sim_exit_top_bench.sv
module sim_exit_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXIT_A = 32'h1000_1FF8;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_valid = 0, bus_we = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [31:0] fetch_data = 32'h0000_0013;
  logic        core_req, retire, halted, halt_pulse;
  logic [31:0] core_addr, halt_code;

  int checks = 0, errors = 0;
  int cyc = 0;
  int strobe_cyc = -1, halt_cyc = -1, last_ret = -1;
  int retire_cnt = 0;
  bit hit_pending = 0, any_write = 0, mon_on = 0;
  logic [31:0] exp_pc = 0, exp_code = 0, step = 4;
  logic [31:0] code_q[$];

  sim_exit_top u_sim_exit_top (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fetch_data(fetch_data), .core_req(core_req),
    .core_addr(core_addr), .retire(retire), .halted(halted),
    .halt_pulse(halt_pulse), .halt_code(halt_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset(input logic [31:0] iw, input logic [31:0] stp);
    @(negedge clk);
    mon_on = 0; rst = 1; fetch_data = iw; step = stp;
    @(negedge clk); @(negedge clk);
    rst = 0; cyc = 0; strobe_cyc = -1; halt_cyc = -1; last_ret = -1;
    retire_cnt = 0; exp_pc = 0; exp_code = 0; any_write = 0;
    // R6 reset state, sampled before the first edge after release
    check(halt_code == 0, "R6 code", halt_code, 0);
    check(!halted && core_req && !retire, "R6 ctrl",
          {halted, core_req, retire}, 3'b010);
    check(core_addr == 32'h0, "R6 pc", core_addr, 0);
    mon_on = 1;
  endtask

  // driver: one-cycle bus write; expected results go to the scoreboard
  task automatic bus_write(input logic [31:0] a, input logic [3:0] be,
                           input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    if (a == EXIT_A && be == 4'hF) begin
      code_q.push_back(d); hit_pending = 1;
    end
    any_write = 1;
    @(negedge clk);
    bus_valid = 0; bus_we = 0; bus_be = 0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor and scoreboard
  always begin
    @(posedge clk); #1;
    if (mon_on) begin
      cyc++;
      if (hit_pending) begin
        hit_pending = 0; strobe_cyc = cyc;
        if (code_q.size() > 0) exp_code = code_q.pop_front();
        check(halt_code == exp_code, "R1 code", halt_code, exp_code);
      end
      // R2 pulse only in the cycle after an accepted write; R3 R4 none otherwise
      check(halt_pulse == (cyc == strobe_cyc), "R2/R3/R4 pulse", halt_pulse,
            cyc == strobe_cyc);
      if (!any_write || strobe_cyc < 0)
        check(halt_code == exp_code, "R3 R4 code kept", halt_code, exp_code);
      // R8 halt point
      if (retire && strobe_cyc >= 0 && cyc > strobe_cyc && halt_cyc < 0)
        halt_cyc = cyc + 1;
      check(halted == (halt_cyc >= 0 && cyc >= halt_cyc), "R8 R9 halted",
            halted, halt_cyc >= 0 && cyc >= halt_cyc);
      if (halted) check(!core_req && !retire, "R9 quiet", {core_req, retire}, 0);
      if (retire) begin
        if (last_ret >= 0) check(cyc - last_ret == 5, "R7 spacing", cyc - last_ret, 5);
        else check(cyc == 4, "R7 first", cyc, 4);
        last_ret = cyc; retire_cnt++;
        exp_pc = exp_pc + step;
      end
      if (core_req) begin
        check(last_ret < 0 ? cyc == 0 : cyc == last_ret + 1, "R7 req",
              cyc, last_ret + 1);
        check(core_addr == exp_pc, "R10 R11 pc", core_addr, exp_pc);
      end
    end
  end

  initial begin
    // sequential instructions
    do_reset(32'h0000_0013, 32'd4);
    wait_cycles(30);
    // R3 partial writes ignored
    bus_write(EXIT_A, 4'b0001, 32'd5);
    bus_write(EXIT_A, 4'b0011, 32'd6);
    // R4 other address ignored
    bus_write(EXIT_A + 4, 4'hF, 32'd7);
    bus_write(32'h1000_0000, 4'hF, 32'd8);
    wait_cycles(12);
    check(!halted, "R3 R4 no halt", halted, 0);
    // R1 full-word write, then R5 read back
    bus_write(EXIT_A, 4'hF, 32'd1);
    @(negedge clk);
    bus_valid = 1; bus_addr = EXIT_A;
    #1 check(bus_rdata == 32'd1, "R5 read", bus_rdata, 1);
    bus_addr = EXIT_A + 4;
    #1 check(bus_rdata == 32'd0, "R5 other read", bus_rdata, 0);
    @(negedge clk); bus_valid = 0;
    wait_cycles(20);
    check(halted && halt_code == 32'd1, "R9 pass held", {31'd0, halted}, 1);

    // self jump keeps running, then fail code at another phase
    do_reset(32'h0000_006F, 32'd0);
    wait_cycles(60);
    check(!halted && retire_cnt >= 10, "R10 spins", retire_cnt, 10);
    wait_cycles(3);
    bus_write(EXIT_A, 4'hF, 32'd31);
    wait_cycles(15);
    check(halted && halt_code == 32'd31, "R8 fail halt", halt_code, 31);

    // forward jump of +8, write placed in each phase
    for (int ph = 0; ph < 5; ph++) begin
      do_reset(32'h0080_006F, 32'd8);
      wait_cycles(11 + ph);
      bus_write(EXIT_A, 4'hF, 32'hA5A5_0000 + ph);
      wait_cycles(14);
      check(halted, "R8 phase halt", halted, 1);
    end
    // read while running has no side effect
    do_reset(32'h0000_0013, 32'd4);
    @(negedge clk); bus_valid = 1; bus_addr = EXIT_A;
    #1 check(bus_rdata == 32'd0, "R5 reset read", bus_rdata, 0);
    @(negedge clk); bus_valid = 0;
    wait_cycles(15);
    check(!halted, "R5 read no halt", halted, 0);
    mon_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule